// File: doc/BRIEF.md
# Audio Streaming DMA Block Counter

This block is the register front end of an audio output DMA that streams fixed-size 32-byte blocks out of memory. Software loads a 32-bit source address through two 16-bit halves and then writes a control word. That write starts a transfer: the control word is stored, the working read pointer is set to the source address, and a block counter is loaded from the length field. The fetch logic reports each finished block on a one-cycle strobe. While streaming is enabled, each strobe moves the read pointer forward by one block and counts down. When the last block is reported, the pointer and counter reload from the source address and the stored length, so the buffer plays in a loop.

Software sees the remaining block count through a read-only register in zero-based form. A separate strobe, raised when software sets the reset bit of the DSP's own control register, clears the control word and so stops streaming. Fetching memory and producing samples are handled elsewhere. The register port is a plain single-cycle write strobe with a combinational read select. It has no back-pressure, because each access completes in the cycle it is presented.

Top module: `aud_stream_ctl`

## Requirements
- R1: After reset, all four registers read zero, the read pointer is zero and the enable output is low.
- R2: A write with select 0 sets source address bits 31:16, and a write with select 1 sets bits 15:0. Each half is written without changing the other, and both halves read back at the same selects.
- R3: A write with select 2 stores the control word, copies the source address into the read pointer, and loads the block counter from bits 14:0. Bit 15 is the enable and drives `stream_en`. The word reads back at select 2.
- R4: A read with select 3 returns the block count minus one, or zero when the count is zero.
- R5: A write with select 3 is ignored: the count, the pointer and all other registers keep their values.
- R6: While enabled, a `blk_done` strobe with a count above one decrements the count by one and advances the read pointer by 32.
- R7: While enabled, a `blk_done` strobe with a count of exactly one reloads the pointer from the source address and the count from the stored length.
- R8: A `blk_done` strobe has no effect while the enable bit is clear or while the count is zero.
- R9: A `dsp_rst_wr` strobe clears the control word to zero. It takes priority over a control write in the same cycle, although that write still loads the pointer and count. The pointer and count are otherwise unchanged.
- R10: When a control write and a `blk_done` strobe occur in the same cycle, the pointer and count take the values loaded by the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write register select (0 src hi, 1 src lo, 2 control, 3 blocks left) |
| reg_wdata | input | 16 | Write data |
| reg_rsel | input | 2 | Read register select, same encoding |
| reg_rdata | output | 16 | Read data, combinational from `reg_rsel` |
| dsp_rst_wr | input | 1 | Strobe: DSP control written with its reset bit set |
| blk_done | input | 1 | Strobe: one block fetched |
| rd_addr | output | 32 | Current read pointer |
| stream_en | output | 1 | Enable bit of the control word |

## Verification
Each write, clear or block strobe takes effect at the rising edge where it is sampled. So `rd_addr`, `stream_en` and the register contents are due one nanosecond after that edge. `reg_rdata` follows `reg_rsel` combinationally inside the same cycle. The bench drives on the falling edge, updates its reference model at the rising edge, and samples every output 1 ns later. It steps through all four read selects before the next falling edge. Same-cycle collisions (clear with control write, control write with block strobe) are driven so that both events land on one edge.

// File: rtl/aud_stream_pkg.sv
`timescale 1ns/100ps
package aud_stream_pkg;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SEL_SRC_HI = 2'd0,
    SEL_SRC_LO = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_LEFT   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/aud_src_pair.sv
`timescale 1ns/100ps
module aud_src_pair #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W/HALF_W-1:0]      wr_half,
  input  logic [HALF_W-1:0]             wdata,
  output logic [ADDR_W-1:0]             src
);
  localparam int NUM_HALVES = ADDR_W / HALF_W;

  for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n)
        src[g*HALF_W +: HALF_W] <= '0;
      else if (wr_half[g])
        src[g*HALF_W +: HALF_W] <= wdata;
    end
  end
endmodule

// File: rtl/aud_ctrl_reg.sv
`timescale 1ns/100ps
module aud_ctrl_reg #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              clear,
  input  logic [HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] ctrl
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl <= '0;
    else if (clear)
      ctrl <= '0;
    else if (wr)
      ctrl <= wdata;
  end
endmodule

// File: rtl/aud_blk_engine.sv
`timescale 1ns/100ps
module aud_blk_engine #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 15,
  parameter int BLK_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              step,
  input  logic [LEN_W-1:0]  loop_len,
  input  logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] ptr,
  output logic [LEN_W-1:0]  cnt
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(BLK_BYTES);
  localparam logic [LEN_W-1:0]  ONE    = LEN_W'(1);

  logic last_blk;
  assign last_blk = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      cnt <= '0;
    end else if (load) begin
      ptr <= src;
      cnt <= load_len;
    end else if (step && cnt != '0) begin
      if (last_blk) begin
        ptr <= src;
        cnt <= loop_len;
      end else begin
        ptr <= ptr + STRIDE;
        cnt <= cnt - ONE;
      end
    end
  end
endmodule

// File: rtl/aud_stream_ctl.sv
`timescale 1ns/100ps
module aud_stream_ctl #(
  parameter int ADDR_W    = 32,
  parameter int HALF_W    = 16,
  parameter int BLK_BYTES = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            reg_wr,
  input  logic [aud_stream_pkg::SEL_W-1:0] reg_sel,
  input  logic [HALF_W-1:0]               reg_wdata,
  input  logic [aud_stream_pkg::SEL_W-1:0] reg_rsel,
  output logic [HALF_W-1:0]               reg_rdata,
  input  logic                            dsp_rst_wr,
  input  logic                            blk_done,
  output logic [ADDR_W-1:0]               rd_addr,
  output logic                            stream_en
);
  import aud_stream_pkg::*;

  localparam int NUM_HALVES = ADDR_W / HALF_W;
  localparam int LEN_W      = HALF_W - 1;
  localparam int EN_BIT     = HALF_W - 1;

  logic [NUM_HALVES-1:0] wr_half;
  logic                  wr_ctrl;
  logic [ADDR_W-1:0]     src_addr;
  logic [HALF_W-1:0]     ctrl_q;
  logic [LEN_W-1:0]      blk_cnt;
  logic [HALF_W-1:0]     left_view;

  always_comb begin
    wr_half             = '0;
    wr_half[NUM_HALVES-1] = reg_wr && (reg_sel == SEL_SRC_HI);
    wr_half[0]          = reg_wr && (reg_sel == SEL_SRC_LO);
  end
  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);

  aud_src_pair #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_src (
    .clk(clk), .rst_n(rst_n), .wr_half(wr_half), .wdata(reg_wdata), .src(src_addr)
  );

  aud_ctrl_reg #(.HALF_W(HALF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .clear(dsp_rst_wr),
    .wdata(reg_wdata), .ctrl(ctrl_q)
  );

  aud_blk_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .load(wr_ctrl), .load_len(reg_wdata[LEN_W-1:0]),
    .step(blk_done && ctrl_q[EN_BIT]), .loop_len(ctrl_q[LEN_W-1:0]),
    .src(src_addr), .ptr(rd_addr), .cnt(blk_cnt)
  );

  assign left_view = (blk_cnt == '0) ? '0 : {1'b0, blk_cnt - LEN_W'(1)};
  assign stream_en = ctrl_q[EN_BIT];

  always_comb begin
    case (reg_rsel)
      SEL_SRC_HI: reg_rdata = src_addr[ADDR_W-1 -: HALF_W];
      SEL_SRC_LO: reg_rdata = src_addr[HALF_W-1:0];
      SEL_CTRL:   reg_rdata = ctrl_q;
      default:    reg_rdata = left_view;
    endcase
  end
endmodule

// File: rtl/aud_stream_ctl_chk.sv
`timescale 1ns/100ps
module aud_stream_ctl_chk #(
  parameter int ADDR_W    = 32,
  parameter int HALF_W    = 16,
  parameter int BLK_BYTES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_sel,
  input logic              dsp_rst_wr,
  input logic              blk_done,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] src_addr,
  input logic [HALF_W-1:0] ctrl_q,
  input logic [HALF_W-2:0] blk_cnt
);
  localparam int LEN_W = HALF_W - 1;
  logic wr_ctrl, en;
  assign wr_ctrl = reg_wr && (reg_sel == 2'd2);
  assign en      = ctrl_q[HALF_W-1];

  p_load_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> rd_addr == $past(src_addr));

  p_left_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3 && !blk_done) |=> $stable(blk_cnt) && $stable(rd_addr));

  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && blk_done && !wr_ctrl && blk_cnt > LEN_W'(1)) |=>
      (blk_cnt == $past(blk_cnt) - LEN_W'(1)) && (rd_addr == $past(rd_addr) + ADDR_W'(BLK_BYTES)));

  p_loop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && blk_done && !wr_ctrl && blk_cnt == LEN_W'(1)) |=>
      (blk_cnt == $past(ctrl_q[LEN_W-1:0])) && (rd_addr == $past(src_addr)));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ctrl && (!en || blk_cnt == '0)) |=> $stable(blk_cnt) && $stable(rd_addr));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_rst_wr |=> ctrl_q == '0);
endmodule

bind aud_stream_ctl aud_stream_ctl_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .BLK_BYTES(BLK_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .dsp_rst_wr(dsp_rst_wr), .blk_done(blk_done), .rd_addr(rd_addr),
  .src_addr(src_addr), .ctrl_q(ctrl_q), .blk_cnt(blk_cnt)
);

// File: tb/aud_stream_ctl_test.sv
`timescale 1ns/100ps
module aud_stream_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [1:0]  reg_rsel = 2'd0;
  logic [15:0] reg_rdata;
  logic        dsp_rst_wr = 1'b0;
  logic        blk_done = 1'b0;
  logic [31:0] rd_addr;
  logic        stream_en;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_src = 0, m_ptr = 0;
  logic [15:0] m_ctrl = 0;
  logic [14:0] m_cnt = 0;

  always #2 clk = ~clk;

  aud_stream_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .dsp_rst_wr(dsp_rst_wr),
    .blk_done(blk_done), .rd_addr(rd_addr), .stream_en(stream_en)
  );

  function automatic logic [15:0] exp_left(input logic [14:0] c);
    return (c == 0) ? 16'd0 : {1'b0, c - 15'd1};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic wr, input logic [1:0] sel, input logic [15:0] d,
                       input logic clr, input logic done);
    logic [31:0] s, p; logic [15:0] c; logic [14:0] k;
    s = m_src; p = m_ptr; c = m_ctrl; k = m_cnt;
    if (wr && sel == 2'd0) s[31:16] = d;
    if (wr && sel == 2'd1) s[15:0] = d;
    if (wr && sel == 2'd2) begin
      p = m_src; k = d[14:0];
    end else if (m_ctrl[15] && done && m_cnt != 0) begin
      if (m_cnt == 1) begin p = m_src; k = m_ctrl[14:0]; end
      else begin p = m_ptr + 32; k = m_cnt - 1; end
    end
    if (clr) c = 16'd0;
    else if (wr && sel == 2'd2) c = d;
    m_src = s; m_ptr = p; m_ctrl = c; m_cnt = k;
  endtask

  // drive at negedge, apply at posedge, check 1 ns later
  task automatic cyc(input logic wr, input logic [1:0] sel, input logic [15:0] d,
                     input logic clr, input logic done, input string req);
    @(negedge clk);
    reg_wr = wr; reg_sel = sel; reg_wdata = d; dsp_rst_wr = clr; blk_done = done;
    @(posedge clk);
    model(wr, sel, d, clr, done);
    #1;
    check({req, " rd_addr"}, rd_addr, m_ptr);
    check({req, " stream_en"}, {31'd0, stream_en}, {31'd0, m_ctrl[15]});
    reg_rsel = 2'd0; #0.2; check({req, " src_hi R2"}, {16'd0, reg_rdata}, {16'd0, m_src[31:16]});
    reg_rsel = 2'd1; #0.2; check({req, " src_lo R2"}, {16'd0, reg_rdata}, {16'd0, m_src[15:0]});
    reg_rsel = 2'd2; #0.2; check({req, " ctrl R3"}, {16'd0, reg_rdata}, {16'd0, m_ctrl});
    reg_rsel = 2'd3; #0.2; check({req, " left R4"}, {16'd0, reg_rdata}, {16'd0, exp_left(m_cnt)});
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0A11);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, "R1 reset");
    cyc(1, 0, 16'h1234, 0, 0, "R2 hi");
    cyc(1, 1, 16'h5600, 0, 0, "R2 lo");
    cyc(1, 0, 16'h1235, 0, 0, "R2 hi only");
    cyc(1, 2, 16'h8003, 0, 0, "R3 start");
    cyc(1, 3, 16'hFFFF, 0, 0, "R5 write left");
    cyc(0, 0, 0, 0, 1, "R6 step1");
    cyc(0, 0, 0, 0, 1, "R6 step2");
    cyc(0, 0, 0, 0, 1, "R7 loop");
    cyc(1, 2, 16'h0002, 0, 0, "R3 disabled");
    cyc(0, 0, 0, 0, 1, "R8 disabled");
    cyc(1, 2, 16'h8000, 0, 0, "R4 zero len");
    cyc(0, 0, 0, 0, 1, "R8 zero count");
    cyc(1, 2, 16'h8004, 0, 0, "R3 restart");
    cyc(0, 0, 0, 1, 0, "R9 clear");
    cyc(0, 0, 0, 0, 1, "R8 after clear");
    cyc(1, 2, 16'h8005, 1, 0, "R9 clear vs write");
    cyc(1, 2, 16'h8006, 0, 0, "R3 reenable");
    cyc(1, 2, 16'h8002, 0, 1, "R10 write vs done");
    cyc(0, 0, 0, 0, 1, "R7 len two loop a");
    cyc(0, 0, 0, 0, 1, "R7 len two loop b");
    for (int i = 0; i < 3000; i++) begin
      int r; logic wr; logic [1:0] sel; logic [15:0] d;
      r = $urandom_range(99);
      wr = (r < 20); sel = 2'($urandom_range(3)); d = 16'($urandom);
      if (sel == 2'd2) d = {($urandom_range(9) != 0), 11'd0, 4'($urandom_range(6))};
      cyc(wr, sel, d, ($urandom_range(59) == 0), ($urandom_range(9) < 6), "R3 R6 R7 R9 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule